// File: doc/BRIEF.md
# Discriminator Hit Timestamp Capture

This block watches sixty-four asynchronous discriminator lines, sixteen from each of four front-end chips. For every rising edge seen while acquisition is open, it records which line fired, which integration timeslice (bunch number) was running, and how many 100 MHz clock cycles had passed since that timeslice began. Records leave through a small first-in first-out buffer that a downstream formatter drains with a read strobe and merges into the spill data block.

Each line is brought into the clock domain and edge-detected. A captured hit stays parked against its own channel, together with its timestamp, until a fixed-priority scan moves it into the buffer. Simultaneous hits are therefore serialised and none is dropped while buffer space exists. A second edge on a channel whose earlier hit has not yet been moved out is lost. Such a loss raises a sticky flag that the next spill start clears. A spill start also restarts the timeslice and fine counters. The block drives a constant per-chip half-select so that each chip exposes its high-gain discriminators.

Top module: `hit_stamp_top`

## Requirements
- R1: After reset, `rec_valid_o` and `overflow_o` are 0.
- R2: The channel number is chip*16 + line, with disc_i bit n equal to channel n. The record layout is rec_o[18:13] = channel, rec_o[12:8] = timeslice, rec_o[7:0] = fine count.
- R3: Each line passes through two synchronising flops and a rising-edge detector. A low-to-high transition yields exactly one record however long the line stays high, and a rising edge is captured three clock edges after the input changes.
- R4: `spill_start_i` zeroes both counters. Otherwise `slice_tick_i` advances the timeslice (saturating at 31) and zeroes the fine count. Otherwise the fine count increments, saturating at 255. A hit carries the counter values of the cycle in which it is captured.
- R5: Rising edges captured while `window_i` is low produce no record.
- R6: Hits captured in the same cycle are emitted in ascending channel order, one per cycle, and none is lost while the buffer has space.
- R7: `rec_valid_o` is high whenever the buffer holds a record, and `rec_o` shows the oldest one. `rd_i` with valid high removes it. With the buffer full (8 records by default), parked hits wait and are not lost.
- R8: An edge captured on a channel whose previous hit is still parked is discarded and sets `overflow_o`. The flag stays set until a cycle with `spill_start_i` high, after which it reads 0. A clear takes priority over a simultaneous set.
- R9: `half_sel_o[c]` is 1 for every chip c, selecting the top half, which holds the high-gain discriminators.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 100 MHz clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| disc_i | input | 64 | Asynchronous discriminator lines |
| slice_tick_i | input | 1 | Integration-period boundary pulse |
| window_i | input | 1 | Acquisition window open |
| spill_start_i | input | 1 | Spill start pulse |
| rd_i | input | 1 | Pop the head record |
| rec_valid_o | output | 1 | Buffer not empty |
| rec_o | output | 19 | Head record {channel, timeslice, fine} |
| overflow_o | output | 1 | Sticky lost-hit flag |
| half_sel_o | output | 4 | Per-chip discriminator half select (1 = top) |

## Verification
The bench fires a line and holds it high. A design that re-triggered on level rather than edge would then emit repeated records. The bench fires twelve channels in one cycle against an eight-deep buffer. A wrong scan would emit them out of order, and dropping instead of parking would lose the last four. It then re-fires a channel that is still parked: the flag must rise and survive until spill start, while the original record keeps its first timestamp. Pulses with the window closed must leave the output empty. Every cycle's record is compared against a behavioural model, so a counter that failed to reset on a tick or saturate would show up as a stamp mismatch.

// File: rtl/hit_stamp_pkg.sv
package hit_stamp_pkg;
  localparam int CH_W    = 6;
  localparam int SLICE_W = 5;
  localparam int FINE_W  = 8;

  typedef struct packed {
    logic [CH_W-1:0]    chan;
    logic [SLICE_W-1:0] slice;
    logic [FINE_W-1:0]  fine;
  } hit_rec_t;

  localparam int REC_W = $bits(hit_rec_t);
endpackage

// File: rtl/disc_sync.sv
module disc_sync #(
  parameter int N = 64
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] line_i,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] s1_q, s2_q, s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= line_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign rise_o = s2_q & ~s3_q;

  p_rise_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|rise_o) |=> ((rise_o & $past(rise_o)) == '0));
endmodule

// File: rtl/slice_timer.sv
module slice_timer
  import hit_stamp_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               spill_start_i,
  input  logic               tick_i,
  output logic [SLICE_W-1:0] slice_o,
  output logic [FINE_W-1:0]  fine_o
);
  localparam logic [SLICE_W-1:0] SLICE_MAX = '1;
  localparam logic [FINE_W-1:0]  FINE_MAX  = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slice_o <= '0;
      fine_o  <= '0;
    end else if (spill_start_i) begin
      slice_o <= '0;
      fine_o  <= '0;
    end else if (tick_i) begin
      if (slice_o != SLICE_MAX) slice_o <= slice_o + 1'b1;
      fine_o <= '0;
    end else if (fine_o != FINE_MAX) begin
      fine_o <= fine_o + 1'b1;
    end
  end

  p_fine_zero_after_tick_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i || spill_start_i) |=> (fine_o == '0));
  p_slice_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !spill_start_i && slice_o != SLICE_MAX) |=> (slice_o == $past(slice_o) + 1'b1));
endmodule

// File: rtl/hit_queue.sv
module hit_queue
  import hit_stamp_pkg::*;
#(
  parameter int N = 64
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N-1:0]       rise_i,
  input  logic               win_i,
  input  logic [SLICE_W-1:0] slice_i,
  input  logic [FINE_W-1:0]  fine_i,
  input  logic               space_i,
  output logic               push_o,
  output hit_rec_t           rec_o,
  output logic               lost_o
);
  logic [N-1:0]       pend_q, cap, grant_vec, busy;
  logic [SLICE_W-1:0] slice_q [N];
  logic [FINE_W-1:0]  fine_q  [N];
  logic [CH_W-1:0]    idx;
  logic               found;

  // lowest index wins
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend_q[i]) begin
        found = 1'b1;
        idx   = CH_W'(i);
      end
    end
  end

  assign push_o    = found && space_i;
  assign grant_vec = push_o ? (N'(1) << idx) : '0;
  assign cap       = rise_i & {N{win_i}};
  assign busy      = pend_q & ~grant_vec;
  assign lost_o    = |(cap & busy);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= busy | cap;
  end

  for (genvar g = 0; g < N; g++) begin : g_stamp
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        slice_q[g] <= '0;
        fine_q[g]  <= '0;
      end else if (cap[g] && !busy[g]) begin
        slice_q[g] <= slice_i;
        fine_q[g]  <= fine_i;
      end
    end
  end

  assign rec_o = '{chan: idx, slice: slice_q[idx], fine: fine_q[idx]};

  p_no_capture_closed_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!win_i && pend_q == '0) |=> (pend_q == '0));
  p_lost_keeps_pending_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lost_o |=> (pend_q != '0));
  p_parked_waits_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!space_i && pend_q != '0) |=> (pend_q != '0));
endmodule

// File: rtl/rec_fifo.sv
module rec_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 19
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic         full_o,
  output logic         valid_o,
  output logic [W-1:0] data_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign valid_o = (cnt_q != '0);
  assign data_o  = mem[rp_q];
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && valid_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= (wp_q == PW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
      if (do_pop)  rp_q <= (rp_q == PW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
      cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wp_q] <= data_i;
  end

  p_full_holds_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && !pop_i) |=> full_o);
  p_count_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
endmodule

// File: rtl/hit_stamp_top.sv
module hit_stamp_top
  import hit_stamp_pkg::*;
#(
  parameter int                NUM_CHIPS      = 4,
  parameter int                LINES_PER_CHIP = 16,
  parameter int                FIFO_DEPTH     = 8,
  parameter logic [NUM_CHIPS-1:0] HIGAIN_TOP  = '1,
  parameter int                NUM_CH         = NUM_CHIPS * LINES_PER_CHIP
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_CH-1:0]    disc_i,
  input  logic                 slice_tick_i,
  input  logic                 window_i,
  input  logic                 spill_start_i,
  input  logic                 rd_i,
  output logic                 rec_valid_o,
  output logic [REC_W-1:0]     rec_o,
  output logic                 overflow_o,
  output logic [NUM_CHIPS-1:0] half_sel_o
);
  logic [NUM_CH-1:0]  rise;
  logic [SLICE_W-1:0] slice;
  logic [FINE_W-1:0]  fine;
  logic               full, push, lost;
  hit_rec_t           cand;

  assign half_sel_o = HIGAIN_TOP;

  disc_sync #(.N(NUM_CH)) i_sync (
    .clk_i, .rst_ni, .line_i(disc_i), .rise_o(rise)
  );

  slice_timer i_timer (
    .clk_i, .rst_ni, .spill_start_i, .tick_i(slice_tick_i),
    .slice_o(slice), .fine_o(fine)
  );

  hit_queue #(.N(NUM_CH)) i_queue (
    .clk_i, .rst_ni, .rise_i(rise), .win_i(window_i),
    .slice_i(slice), .fine_i(fine), .space_i(!full),
    .push_o(push), .rec_o(cand), .lost_o(lost)
  );

  rec_fifo #(.DEPTH(FIFO_DEPTH), .W(REC_W)) i_fifo (
    .clk_i, .rst_ni, .push_i(push), .data_i(cand), .pop_i(rd_i),
    .full_o(full), .valid_o(rec_valid_o), .data_o(rec_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            overflow_o <= 1'b0;
    else if (spill_start_i) overflow_o <= 1'b0;
    else if (lost)          overflow_o <= 1'b1;
  end

  p_overflow_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overflow_o && !spill_start_i) |=> overflow_o);
  p_overflow_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spill_start_i |=> !overflow_o);
endmodule

// File: tb/test_hit_stamp_top.sv
module test_hit_stamp_top;
  localparam int NCH = 64;
  localparam int DEP = 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NCH-1:0] disc = '0;
  logic           tick = 1'b0, win = 1'b0, spill = 1'b0, rd = 1'b0;
  logic           rec_valid, ovf;
  logic [18:0]    rec;
  logic [3:0]     half_sel;
  int checks = 0, errors = 0;
  bit tick_en = 1'b0;
  int tick_cnt = 0;

  always #5 clk = ~clk;

  hit_stamp_top i_hit_stamp_top (
    .clk_i(clk), .rst_ni(rst_n), .disc_i(disc), .slice_tick_i(tick),
    .window_i(win), .spill_start_i(spill), .rd_i(rd),
    .rec_valid_o(rec_valid), .rec_o(rec), .overflow_o(ovf), .half_sel_o(half_sel)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [NCH-1:0] m_s1, m_s2, m_s3;
  bit   m_pend [NCH];
  int   m_sl [NCH], m_fi [NCH];
  logic [18:0] m_q [$];
  int   m_slice, m_fine;
  bit   m_ovf;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = '0; m_s2 = '0; m_s3 = '0;
      foreach (m_pend[i]) begin m_pend[i] = 0; m_sl[i] = 0; m_fi[i] = 0; end
      m_q.delete(); m_slice = 0; m_fine = 0; m_ovf = 0;
    end else begin
      int g; bit lost_ev; logic [18:0] newrec;
      g = -1;
      if (m_q.size() < DEP)
        for (int i = 0; i < NCH; i++) if (m_pend[i] && g < 0) g = i;
      if (g >= 0) newrec = {6'(g), 5'(m_sl[g]), 8'(m_fi[g])};
      if (rd && m_q.size() > 0) void'(m_q.pop_front());
      if (g >= 0) begin m_q.push_back(newrec); m_pend[g] = 0; end
      lost_ev = 0;
      for (int i = 0; i < NCH; i++) begin
        if (m_s2[i] && !m_s3[i] && win) begin
          if (m_pend[i]) lost_ev = 1;
          else begin m_pend[i] = 1; m_sl[i] = m_slice; m_fi[i] = m_fine; end
        end
      end
      if (spill) m_ovf = 0; else if (lost_ev) m_ovf = 1;
      if (spill) begin m_slice = 0; m_fine = 0; end
      else if (tick) begin if (m_slice < 31) m_slice++; m_fine = 0; end
      else if (m_fine < 255) m_fine++;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = disc;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      check(rec_valid == (m_q.size() > 0), "R7 valid", rec_valid, m_q.size() > 0);
      if (m_q.size() > 0) check(rec == m_q[0], "R4 record", rec, m_q[0]);
      check(ovf == m_ovf, "R8 overflow", ovf, m_ovf);
    end
  end

  always @(negedge clk) begin
    tick <= 1'b0;
    if (tick_en) begin
      tick_cnt++;
      if (tick_cnt == 20) begin tick <= 1'b1; tick_cnt = 0; end
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pop_expect(input int ch, input string req);
    int t = 0;
    while (!rec_valid && t < 300) begin @(negedge clk); t++; end
    check(rec_valid && rec[18:13] == 6'(ch), req, rec[18:13], ch);
    rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cycles(3);
    check(rec_valid == 1'b0, "R1 valid", rec_valid, 0);
    check(ovf == 1'b0, "R1 overflow", ovf, 0);
    check(half_sel == 4'hF, "R9 half select", half_sel, 4'hF);
    @(negedge clk); rst_n = 1'b1;
    cycles(2);
    spill = 1'b1; win = 1'b1; tick_en = 1'b1;
    @(negedge clk); spill = 1'b0;
    cycles(7);

    // R3 / R2: single edge, line held high (chip 2, line 5 = channel 37)
    disc[37] = 1'b1;
    cycles(3);
    check(rec_valid == 1'b0, "R3 latency", rec_valid, 0);
    pop_expect(37, "R2 channel");
    cycles(10);
    check(rec_valid == 1'b0, "R3 held line single record", rec_valid, 0);
    disc[37] = 1'b0;
    cycles(5);

    // R6: simultaneous hits, ascending order
    disc[40] = 1'b1; disc[3] = 1'b1; disc[17] = 1'b1;
    cycles(3);
    disc = '0;
    pop_expect(3, "R6 order first");
    pop_expect(17, "R6 order second");
    pop_expect(40, "R6 order third");
    cycles(3);
    check(rec_valid == 1'b0, "R6 no extra", rec_valid, 0);

    // R5: window closed
    win = 1'b0;
    disc[5] = 1'b1; disc[50] = 1'b1;
    cycles(3);
    disc = '0;
    cycles(8);
    win = 1'b1;
    cycles(4);
    check(rec_valid == 1'b0, "R5 closed window", rec_valid, 0);

    // R7 / R8: twelve hits into eight-deep buffer, then re-fire a parked one
    begin
      int chans [12] = '{1, 2, 9, 14, 20, 33, 41, 47, 50, 55, 58, 60};
      foreach (chans[k]) disc[chans[k]] = 1'b1;
      cycles(3);
      disc = '0;
      cycles(20);
      check(rec_valid == 1'b1, "R7 buffer filled", rec_valid, 1);
      check(ovf == 1'b0, "R8 no loss while parked", ovf, 0);
      disc[60] = 1'b1;
      cycles(4);
      disc[60] = 1'b0;
      check(ovf == 1'b1, "R8 overflow set", ovf, 1);
      cycles(30);
      check(ovf == 1'b1, "R8 overflow sticky", ovf, 1);
      foreach (chans[k]) pop_expect(chans[k], "R7 drain no loss");
      cycles(4);
      check(rec_valid == 1'b0, "R8 dropped hit not queued", rec_valid, 0);
    end
    spill = 1'b1;
    @(negedge clk); spill = 1'b0;
    check(ovf == 1'b0, "R8 cleared at spill", ovf, 0);

    // R4: stamp after restart, mid slice
    cycles(45);
    disc[63] = 1'b1;
    cycles(3);
    disc[63] = 1'b0;
    pop_expect(63, "R4 late channel");
    cycles(5);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule